// File: doc/BRIEF.md
# Sector Erase Accumulation Timer

This block sits in the command path of a flash-style storage device. It takes sector-erase requests that have already been decoded, gathers the addressed sectors into a bitmap, and holds that set open for a fixed acceptance window. Every accepted sector request adds its bit and restarts the whole window. When a full window passes with no new accepted request, the block commits. It raises a status flag, which a host reads as status bit 3, and it sends a one-cycle start pulse to the erase engine along with the final bitmap.

Once the block has committed, it ignores every command except erase-suspend until the engine reports done. A chip-erase request taken while idle skips the window: it starts at once with every sector selected, and the status flag stays low. Requests the block cannot take are counted in a drop counter, which the bench uses to see them. The window length is a parameter counted in clock cycles. A host that issues its sector requests closer together than the window does not need to poll the flag.

Top module: `sect_erase_gather`

## Requirements
- R1: After reset, sector_map, win_shut, erase_go, erase_all, susp_go and drop_cnt are all zero.
- R2: A sector request with index i < NUM_SECT taken while idle sets bit i of sector_map one cycle later, and win_shut stays 0.
- R3: Exactly WIN_CYC clock edges after the last accepted sector request, win_shut goes from 0 to 1. erase_go is 1 for that one cycle only.
- R4: A valid sector request inside the open window sets its bit and restarts the full WIN_CYC window. This also holds when the bit is already set.
- R5: While win_shut is 1, sector and chip requests change neither sector_map nor win_shut.
- R6: A chip request taken while idle gives erase_all = 1, all NUM_SECT bits of sector_map set, and a one-cycle erase_go on the next cycle. win_shut stays 0 throughout.
- R7: drop_cnt rises by one for each cycle in which a sector or chip strobe is not accepted. It saturates at 2^DROP_W - 1.
- R8: An erase-suspend strobe while an erase runs (win_shut or erase_all high) and eng_done is low gives a one-cycle susp_go on the next cycle. The same strobe while idle or during the open window has no effect.
- R9: eng_done while an erase runs clears sector_map, win_shut and erase_all on the next cycle, and the block then accepts new requests. eng_done while idle or gathering has no effect.
- R10: A sector request with index >= NUM_SECT sets no bit, does not start or restart the window, and counts as dropped.
- R11: A chip request while the window is open is ignored and counts as dropped. If a chip request and a sector request arrive in the same idle cycle, the chip request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_sector_vld | input | 1 | Sector-erase request strobe |
| cmd_sector_idx | input | IDX_W | Sector index of the request |
| cmd_suspend | input | 1 | Erase-suspend strobe |
| cmd_chip | input | 1 | Chip-erase request strobe |
| eng_done | input | 1 | Erase engine reports completion |
| sector_map | output | NUM_SECT | Selected sectors |
| win_shut | output | 1 | Status bit 3: window closed, sector erase running |
| erase_go | output | 1 | One-cycle erase start pulse |
| erase_all | output | 1 | Chip erase running |
| susp_go | output | 1 | One-cycle suspend request to the engine |
| drop_cnt | output | DROP_W | Saturating count of refused requests |

## Verification
A wrong window timer shows up as win_shut and erase_go moving a cycle early or late against the last accepted request. This is visible at the first closing edge after that request. A corrupt state register shows up as a missing or extra erase_go, or as a map that changes while win_shut is high, within one cycle of the next strobe. A fault in the bitmap or the drop counter shows on the next clock edge after the strobe that touches it. For that reason every output is compared against a behavioural model on every cycle.

// File: rtl/sew_pkg.sv
package sew_pkg;
   typedef enum logic [1:0] {
      SEW_IDLE   = 2'd0,
      SEW_GATHER = 2'd1,
      SEW_RUN    = 2'd2,
      SEW_CHIP   = 2'd3
   } sew_state_e;
endpackage

// File: rtl/sew_timer.sv
module sew_timer #(
   parameter int WIN_CYC = 20,
   localparam int TMR_W = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic dec,
   output logic zero
);
   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= TMR_W'(WIN_CYC - 1);
      else if (dec && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/sew_map.sv
module sew_map #(
   parameter int NUM_SECT = 48,
   parameter int IDX_W    = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                fill,
   input  logic                set_en,
   input  logic [IDX_W-1:0]    set_idx,
   output logic [NUM_SECT-1:0] map
);
   for (genvar i = 0; i < NUM_SECT; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n || clr)
            map[i] <= 1'b0;
         else if (fill)
            map[i] <= 1'b1;
         else if (set_en && set_idx == IDX_W'(i))
            map[i] <= 1'b1;
      end
   end
endmodule

// File: rtl/sew_dropcnt.sv
module sew_dropcnt #(
   parameter int DROP_W   = 8,
   parameter bit SAT_DROP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bump,
   output logic [DROP_W-1:0] cnt
);
   if (SAT_DROP) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt <= '0;
         else if (bump && cnt != '1)
            cnt <= cnt + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt <= '0;
         else if (bump)
            cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sect_erase_gather.sv
module sect_erase_gather
   import sew_pkg::*;
#(
   parameter int NUM_SECT = 48,
   parameter int IDX_W    = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
   parameter int WIN_CYC  = 20,
   parameter int DROP_W   = 8,
   parameter bit SAT_DROP = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_sector_vld,
   input  logic [IDX_W-1:0]    cmd_sector_idx,
   input  logic                cmd_suspend,
   input  logic                cmd_chip,
   input  logic                eng_done,
   output logic [NUM_SECT-1:0] sector_map,
   output logic                win_shut,
   output logic                erase_go,
   output logic                erase_all,
   output logic                susp_go,
   output logic [DROP_W-1:0]   drop_cnt
);
   if (NUM_SECT < 1 || NUM_SECT > 4096) begin : g_bad_sect
      $error("NUM_SECT out of range");
   end
   if ((1 << IDX_W) < NUM_SECT) begin : g_bad_idx
      $error("IDX_W too narrow for NUM_SECT");
   end
   if (WIN_CYC < 2) begin : g_bad_win
      $error("WIN_CYC must be at least 2");
   end
   if (DROP_W < 1) begin : g_bad_drop
      $error("DROP_W must be positive");
   end

   sew_state_e st_q, st_d;
   logic idx_ok, take_sect, take_chip, busy, tmr_zero, expire, refuse;

   assign idx_ok    = ({1'b0, cmd_sector_idx} < (IDX_W+1)'(NUM_SECT));
   assign busy      = (st_q == SEW_RUN) || (st_q == SEW_CHIP);
   assign take_chip = cmd_chip && (st_q == SEW_IDLE);
   assign take_sect = cmd_sector_vld && idx_ok &&
                      (((st_q == SEW_IDLE) && !cmd_chip) || (st_q == SEW_GATHER));
   assign expire    = (st_q == SEW_GATHER) && !take_sect && tmr_zero;
   assign refuse    = (cmd_sector_vld && !take_sect) || (cmd_chip && !take_chip);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         SEW_IDLE: begin
            if (take_chip)      st_d = SEW_CHIP;
            else if (take_sect) st_d = SEW_GATHER;
         end
         SEW_GATHER: if (expire) st_d = SEW_RUN;
         SEW_RUN:    if (eng_done) st_d = SEW_IDLE;
         SEW_CHIP:   if (eng_done) st_d = SEW_IDLE;
         default:    st_d = SEW_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= SEW_IDLE;
         win_shut  <= 1'b0;
         erase_all <= 1'b0;
         erase_go  <= 1'b0;
         susp_go   <= 1'b0;
      end else begin
         st_q      <= st_d;
         win_shut  <= (st_d == SEW_RUN);
         erase_all <= (st_d == SEW_CHIP);
         erase_go  <= expire || take_chip;
         susp_go   <= busy && cmd_suspend && !eng_done;
      end
   end

   sew_timer #(.WIN_CYC(WIN_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (take_sect),
      .dec   (st_q == SEW_GATHER),
      .zero  (tmr_zero)
   );

   sew_map #(.NUM_SECT(NUM_SECT), .IDX_W(IDX_W)) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (busy && eng_done),
      .fill    (take_chip),
      .set_en  (take_sect),
      .set_idx (cmd_sector_idx),
      .map     (sector_map)
   );

   sew_dropcnt #(.DROP_W(DROP_W), .SAT_DROP(SAT_DROP)) u_drop (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (refuse),
      .cnt   (drop_cnt)
   );
endmodule

// File: rtl/sew_chk.sv
module sew_chk #(
   parameter int NUM_SECT = 48,
   parameter int DROP_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cmd_sector_vld,
   input logic                cmd_chip,
   input logic                eng_done,
   input logic [NUM_SECT-1:0] sector_map,
   input logic                win_shut,
   input logic                erase_go,
   input logic                erase_all,
   input logic                susp_go,
   input logic [DROP_W-1:0]   drop_cnt
);
   assert_go_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      erase_go |=> !erase_go);

   assert_rise_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_shut) |-> erase_go);

   assert_shut_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_shut && !eng_done) |=> ($stable(sector_map) && win_shut));

   assert_chip_noshut_R6: assert property (@(posedge clk) disable iff (!rst_n)
      erase_all |-> !win_shut);

   assert_quiet_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_sector_vld && !cmd_chip) |=> $stable(drop_cnt));

   assert_susp_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      susp_go |-> (win_shut || erase_all));

   assert_done_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((win_shut || erase_all) && eng_done) |=>
         (sector_map == '0 && !win_shut && !erase_all));
endmodule

bind sect_erase_gather sew_chk #(.NUM_SECT(NUM_SECT), .DROP_W(DROP_W)) u_chk (.*);

// File: tb/sect_erase_gather_bench.sv
module sect_erase_gather_bench;
   localparam int NS = 48;
   localparam int IW = 6;
   localparam int WC = 20;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vld = 1'b0, susp = 1'b0, chip = 1'b0, done = 1'b0;
   logic [IW-1:0] idx = '0;
   logic [NS-1:0] map;
   logic shut, go, all, sgo;
   logic [DW-1:0] drop;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   sect_erase_gather #(.NUM_SECT(NS), .IDX_W(IW), .WIN_CYC(WC), .DROP_W(DW)) u_sect_erase_gather (
      .clk(clk), .rst_n(rst_n), .cmd_sector_vld(vld), .cmd_sector_idx(idx),
      .cmd_suspend(susp), .cmd_chip(chip), .eng_done(done),
      .sector_map(map), .win_shut(shut), .erase_go(go), .erase_all(all),
      .susp_go(sgo), .drop_cnt(drop));

   // behavioural reference: 0 idle, 1 gathering, 2 sector erase, 3 chip erase
   int m_st = 0, m_left = 0, m_drop = 0;
   logic [NS-1:0] m_map = '0;
   bit m_shut = 0, m_go = 0, m_all = 0, m_sgo = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_left = 0; m_drop = 0; m_map = '0;
         m_shut = 0; m_go = 0; m_all = 0; m_sgo = 0;
      end else begin
         bit refused;
         refused = 0;
         m_go = 0;
         m_sgo = 0;
         if (m_st == 0) begin
            if (chip) begin
               m_st = 3; m_all = 1; m_map = '1; m_go = 1;
               if (vld) refused = 1;
            end else if (vld) begin
               if (int'(idx) < NS) begin
                  m_map[idx] = 1'b1; m_left = WC; m_st = 1;
               end else refused = 1;
            end
         end else if (m_st == 1) begin
            if (chip) refused = 1;
            if (vld && int'(idx) < NS) begin
               m_map[idx] = 1'b1; m_left = WC;
            end else begin
               if (vld) refused = 1;
               m_left--;
               if (m_left == 0) begin
                  m_st = 2; m_shut = 1; m_go = 1;
               end
            end
         end else begin
            if (vld || chip) refused = 1;
            if (done) begin
               m_st = 0; m_map = '0; m_shut = 0; m_all = 0;
            end else if (susp) m_sgo = 1;
         end
         if (refused && m_drop < (1 << DW) - 1) m_drop++;
      end
   end

   task automatic chk(string tag, longint act, longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R4 map vs model", longint'(map), longint'(m_map));
         chk("R3 win_shut vs model", longint'(shut), longint'(m_shut));
         chk("R3 erase_go vs model", longint'(go), longint'(m_go));
         chk("R6 erase_all vs model", longint'(all), longint'(m_all));
         chk("R8 susp_go vs model", longint'(sgo), longint'(m_sgo));
         chk("R7 drop_cnt vs model", longint'(drop), longint'(m_drop));
      end
   end

   task automatic idle(int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask
   task automatic sect(int i);
      @(negedge clk); vld = 1'b1; idx = IW'(i);
      @(negedge clk); vld = 1'b0;
   endtask
   task automatic one(ref logic s);
      @(negedge clk); s = 1'b1;
      @(negedge clk); s = 1'b0;
   endtask

   localparam longint B5 = 64'd1 << 5;
   localparam longint B9 = 64'd1 << 9;

   initial begin
      idle(3);
      chk("R1 map reset", longint'(map), 0);
      chk("R1 flags reset", {shut, go, all, sgo}, 0);
      chk("R1 drop reset", longint'(drop), 0);
      @(negedge clk); rst_n = 1'b1;

      sect(5);
      chk("R2 first bit", longint'(map), B5);
      chk("R2 shut low", longint'(shut), 0);
      idle(10);
      sect(9);
      idle(18);
      chk("R4 window restarted", longint'(shut), 0);
      idle(1);
      chk("R3 one edge early", longint'(shut), 0);
      idle(1);
      chk("R3 closed", longint'(shut), 1);
      chk("R3 go pulse", longint'(go), 1);

      sect(7);
      chk("R5 map frozen", longint'(map), B5 | B9);
      one(chip);
      chk("R5 chip ignored", longint'({shut, all}), 2);
      one(susp);
      chk("R8 suspend forwarded", longint'(sgo), 1);
      one(done);
      chk("R9 cleared", longint'({map != '0, shut, all}), 0);

      one(done);
      chk("R9 done in idle", longint'(map), 0);
      sect(50);
      chk("R10 out of range", longint'(map), 0);
      sect(47);
      one(chip);
      chk("R11 chip in window", longint'(all), 0);
      one(susp);
      chk("R8 suspend in window", longint'(sgo), 0);
      idle(25);
      one(done);

      one(chip);
      chk("R6 chip map", longint'(map), (64'd1 << NS) - 1);
      chk("R6 chip flags", longint'({all, shut}), 2);
      one(susp);
      one(done);

      @(negedge clk); vld = 1'b1; chip = 1'b1; idx = 6'd3;
      @(negedge clk); vld = 1'b0; chip = 1'b0;
      chk("R11 chip wins", longint'(all), 1);
      one(done);

      sect(1);
      idle(25);
      @(negedge clk); vld = 1'b1;
      idle(300);
      vld = 1'b0;
      idle(1);
      chk("R7 saturated", longint'(drop), 255);
      one(done);
      idle(3);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!finished) begin
         finished = 1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule